// File: doc/BRIEF.md
# CPU-to-PCI Address Window Decoder

This block maps 32-bit CPU addresses onto programmable address windows. There are two PCI buses. Each bus has one I/O window and four memory windows. One further window covers the internal register space. Every window holds a base, a size and a 64-bit translation value. When a lookup address falls inside an enabled window, the block reports a hit, the index of the matching window and the translated bus address. The lookup path is purely combinational.

Configuration goes through a simple word-addressed register port. A write takes effect at the next clock edge, and a read returns data combinationally. A global configuration word decides whether a base write also reloads the low half of that window's translation value. A 21-bit enable word, with active-low bits, switches the windows on and off. Window indices run as follows:
- 0 to 4: bus 0 (I/O, then memory 0 to 3)
- 5 to 9: bus 1 (I/O, then memory 0 to 3)
- 10: register space

Top module: `cpuwin_decoder`

## Requirements
- R1: After reset the registers hold these values:
  - configuration reads 0x00800000
  - enable reads 0x0fbfff
  - the register-space base (window 10) reads 0x0100f100
  - every other base, size and translation register reads 0
- R2: The enable register keeps only bits 20:0 of a write. A window is enabled while its bit is 0. Windows 0–9 use enable bits 9–18 in index order, and window 10 uses bit 20.
- R3: A window starts at base[19:0] << 16 and spans (size[15:0] + 1) << 16 bytes. The address is compared at 36-bit width, so base bits 19:16 can place a window above the 32-bit CPU space. The window hits when start <= address < start + span.
- R4: Base writes are masked as follows: memory windows with 0x070fffff, I/O windows with 0x030fffff, and the register-space window with 0x000fffff. Size writes keep bits 15:0.
- R5: A low-translation write puts wdata[15:0] into translation[31:16] and leaves bits 63:32 unchanged. A high-translation write (memory windows only) puts wdata into bits 63:32 and leaves bits 31:0 unchanged.
- R6: Reads of the translation registers return:
  - low-translation read, memory window: translation[31:16] in bits 15:0
  - low-translation read, I/O window: translation >> 16, truncated to 32 bits
  - high-translation read: translation[63:32]
- R7: While configuration bit 27 is 0, a base write to windows 0–9 also copies wdata[15:0] into translation[31:16]. While the bit is 1, no copy takes place.
- R8: Configuration writes are masked with 0x0e4e3bff, and bit 23 is always forced to 1.
- R9: On a hit, the bus address equals translation + (address − window start), modulo 2^64.
- R10: When several enabled windows contain the address, the lowest window index wins.
- R11: Lookup is combinational. The hit, index and bus-address outputs follow the lookup address in the same cycle. On a miss, the index and the bus address are 0.
- R12: The register map works as follows:
  - address 0x00: configuration
  - address 0x01: enable
  - window w, field f: address 0x10 + 4w + f, where f is 0 base, 1 size, 2 low translation, 3 high translation
  - Unmapped addresses read 0 and ignore writes.
  - The register-space window's size and translation fields, and the I/O windows' high field, read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| lk_addr | input | 32 | CPU address to decode |
| lk_hit | output | 1 | Address falls in an enabled window |
| lk_win | output | 4 | Index of the winning window |
| lk_bus_addr | output | 64 | Translated bus address |

## Verification
The bench builds the block with its default parameters: two buses, four memory windows per bus and a 21-bit enable word. With these values all eleven windows, both base masks and the active-low enable mapping are reachable. The defaults also make it possible to place a window at the very top of the 32-bit space, where the translation reaches all-ones. A base whose bits 19:16 are set lands beyond the CPU range, and the bench checks that this window never hits. Overlapping memory windows on bus 0 exercise the priority rule and the exact end of a window span.

// File: rtl/cwd_pkg.sv
package cwd_pkg;

  typedef enum logic [1:0] {
    WK_IO   = 2'd0,
    WK_MEM  = 2'd1,
    WK_REGS = 2'd2
  } win_kind_e;

  localparam logic [31:0] MEM_BASE_MASK  = 32'h070f_ffff;
  localparam logic [31:0] IO_BASE_MASK   = 32'h030f_ffff;
  localparam logic [31:0] REGS_BASE_MASK = 32'h000f_ffff;

  // Kind of window w, given windows per bus and total window count.
  function automatic win_kind_e win_kind_of(input int w, input int wpb, input int nwin);
    if (w == nwin - 1)      return WK_REGS;
    else if ((w % wpb) == 0) return WK_IO;
    else                     return WK_MEM;
  endfunction

  function automatic logic [31:0] base_mask_of(input win_kind_e k);
    case (k)
      WK_MEM:  return MEM_BASE_MASK;
      WK_IO:   return IO_BASE_MASK;
      default: return REGS_BASE_MASK;
    endcase
  endfunction

  // First byte of a window, 36 bits wide.
  function automatic logic [35:0] win_start(input logic [19:0] base_f);
    return {base_f, 16'h0000};
  endfunction

  // One past the last byte of a window, 37 bits wide.
  function automatic logic [36:0] win_end(input logic [19:0] base_f, input logic [15:0] size_f);
    logic [16:0] blocks;
    blocks = {1'b0, size_f} + 17'd1;
    return {1'b0, base_f, 16'h0000} + {4'h0, blocks, 16'h0000};
  endfunction

  // Bus address from translation value and offset inside the window.
  function automatic logic [63:0] xlate(input logic [63:0] remap, input logic [31:0] offset);
    return remap + {32'h0, offset};
  endfunction

endpackage

// File: rtl/cwd_window_regs.sv
module cwd_window_regs
  import cwd_pkg::*;
#(
  parameter win_kind_e   KIND     = WK_MEM,
  parameter logic [31:0] BASE_RST = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_base,
  input  logic        wr_size,
  input  logic        wr_rlo,
  input  logic        wr_rhi,
  input  logic [31:0] wdata,
  input  logic        copy_en,
  output logic [31:0] base_q,
  output logic [15:0] size_q,
  output logic [63:0] remap_q
);
  localparam logic [31:0] BMASK    = base_mask_of(KIND);
  localparam bit          HAS_XL   = (KIND != WK_REGS);
  localparam bit          HAS_HIGH = (KIND == WK_MEM);

  wire base_copy = wr_base && copy_en && HAS_XL;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= BASE_RST;
      size_q  <= '0;
      remap_q <= '0;
    end else begin
      if (wr_base) base_q <= wdata & BMASK;
      if (wr_size && HAS_XL) size_q <= wdata[15:0];
      if (base_copy || (wr_rlo && HAS_XL)) remap_q[31:16] <= wdata[15:0];
      if (wr_rhi && HAS_HIGH) remap_q[63:32] <= wdata;
    end
  end

  // R5
  rlo_keeps_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rlo |=> $stable(remap_q[63:32]));

  // R5
  rhi_keeps_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rhi && !wr_base && !wr_rlo) |=> $stable(remap_q[31:0]));

  generate
    if (HAS_XL) begin : g_copy_chk
      // R7
      base_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_base && copy_en) |=> (remap_q[31:16] == $past(wdata[15:0])));
      // R7
      base_nocopy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_base && !copy_en && !wr_rlo) |=> $stable(remap_q[31:16]));
    end
  endgenerate

endmodule

// File: rtl/cwd_match.sv
module cwd_match
  import cwd_pkg::*;
(
  input  logic [31:0] lk_addr,
  input  logic        enabled,
  input  logic [19:0] base_f,
  input  logic [15:0] size_f,
  output logic        hit,
  output logic [31:0] offset
);
  logic [35:0] start;
  logic [36:0] limit;
  logic [35:0] addr_w;
  logic        above_start;
  logic        below_end;

  assign start       = win_start(base_f);
  assign limit       = win_end(base_f, size_f);
  assign addr_w      = {4'h0, lk_addr};
  assign above_start = (addr_w >= start);
  assign below_end   = ({1'b0, addr_w} < limit);
  assign hit         = enabled && above_start && below_end;
  assign offset      = lk_addr - start[31:0];
endmodule

// File: rtl/cwd_select.sv
module cwd_select
  import cwd_pkg::*;
#(
  parameter int NWIN  = 11,
  parameter int IDX_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NWIN-1:0]       hit_vec,
  input  logic [NWIN-1:0][31:0] offs,
  input  logic [NWIN-1:0][63:0] remaps,
  output logic                  hit_o,
  output logic [IDX_W-1:0]      idx_o,
  output logic [63:0]           bus_o
);
  logic [NWIN-1:0] lower_hits;

  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int w = NWIN - 1; w >= 0; w--) begin
      if (hit_vec[w]) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(w);
      end
    end
  end

  assign bus_o      = hit_o ? xlate(remaps[idx_o], offs[idx_o]) : 64'h0;
  assign lower_hits = hit_vec & ((NWIN'(1) << idx_o) - NWIN'(1));

  // R10
  lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> (hit_vec[idx_o] && (lower_hits == '0)));

  // R11
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_o |-> ((hit_vec == '0) && (idx_o == '0) && (bus_o == 64'h0)));

endmodule

// File: rtl/cpuwin_decoder.sv
module cpuwin_decoder
  import cwd_pkg::*;
#(
  parameter int          NUM_BUS       = 2,
  parameter int          MEM_PER_BUS   = 4,
  parameter int          EN_W          = 21,
  parameter int          FIRST_EN_BIT  = 9,
  parameter int          REGS_EN_BIT   = 20,
  parameter logic [31:0] EN_RST        = 32'h000f_bfff,
  parameter logic [31:0] CFG_RST       = 32'h0080_0000,
  parameter logic [31:0] CFG_MASK      = 32'h0e4e_3bff,
  parameter int          FORCE_BIT     = 23,
  parameter int          NOCOPY_BIT    = 27,
  parameter logic [31:0] REGS_BASE_RST = 32'h0100_f100,
  parameter int          CFG_AW        = 8,
  parameter int          WIN_REG_BASE  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic [31:0]       lk_addr,
  output logic              lk_hit,
  output logic [3:0]        lk_win,
  output logic [63:0]       lk_bus_addr
);
  localparam int WPB   = 1 + MEM_PER_BUS;
  localparam int NWIN  = NUM_BUS * WPB + 1;
  localparam int IDX_W = $clog2(NWIN);
  localparam logic [CFG_AW-1:0] ADDR_CFG = CFG_AW'(0);
  localparam logic [CFG_AW-1:0] ADDR_EN  = CFG_AW'(1);

  logic [31:0]     cfg_q;
  logic [EN_W-1:0] en_q;

  logic [CFG_AW-1:0] rel;
  logic              in_win;
  logic [CFG_AW-3:0] w_sel;
  logic [1:0]        fld;

  logic [NWIN-1:0][31:0] base_a;
  logic [NWIN-1:0][15:0] size_a;
  logic [NWIN-1:0][63:0] remap_a;
  logic [NWIN-1:0][31:0] offs_a;
  logic [NWIN-1:0]       hit_vec;
  logic [IDX_W-1:0]      sel_idx;

  wire copy_en = ~cfg_q[NOCOPY_BIT];

  assign rel    = cfg_addr - CFG_AW'(WIN_REG_BASE);
  assign in_win = (cfg_addr >= CFG_AW'(WIN_REG_BASE)) && (int'(rel) < NWIN * 4);
  assign w_sel  = rel[CFG_AW-1:2];
  assign fld    = rel[1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= CFG_RST;
      en_q  <= EN_RST[EN_W-1:0];
    end else if (cfg_we) begin
      if (cfg_addr == ADDR_CFG) cfg_q <= (cfg_wdata & CFG_MASK) | (32'h1 << FORCE_BIT);
      if (cfg_addr == ADDR_EN)  en_q  <= cfg_wdata[EN_W-1:0];
    end
  end

  generate
    for (genvar w = 0; w < NWIN; w++) begin : g_win
      localparam win_kind_e   K  = win_kind_of(w, WPB, NWIN);
      localparam int          EB = (w == NWIN - 1) ? REGS_EN_BIT : FIRST_EN_BIT + w;
      localparam logic [31:0] BR = (K == WK_REGS) ? REGS_BASE_RST : 32'h0;

      wire wsel = cfg_we && in_win && (int'(w_sel) == w);

      cwd_window_regs #(.KIND(K), .BASE_RST(BR)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_base (wsel && (fld == 2'd0)),
        .wr_size (wsel && (fld == 2'd1)),
        .wr_rlo  (wsel && (fld == 2'd2)),
        .wr_rhi  (wsel && (fld == 2'd3)),
        .wdata   (cfg_wdata),
        .copy_en (copy_en),
        .base_q  (base_a[w]),
        .size_q  (size_a[w]),
        .remap_q (remap_a[w])
      );

      cwd_match u_match (
        .lk_addr (lk_addr),
        .enabled (~en_q[EB]),
        .base_f  (base_a[w][19:0]),
        .size_f  (size_a[w]),
        .hit     (hit_vec[w]),
        .offset  (offs_a[w])
      );

      // R2
      en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_vec[w] |-> !en_q[EB]);
    end
  endgenerate

  cwd_select #(.NWIN(NWIN), .IDX_W(IDX_W)) u_sel (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit_vec (hit_vec),
    .offs    (offs_a),
    .remaps  (remap_a),
    .hit_o   (lk_hit),
    .idx_o   (sel_idx),
    .bus_o   (lk_bus_addr)
  );

  assign lk_win = 4'(sel_idx);

  always_comb begin
    cfg_rdata = 32'h0;
    if (cfg_addr == ADDR_CFG) begin
      cfg_rdata = cfg_q;
    end else if (cfg_addr == ADDR_EN) begin
      cfg_rdata = 32'(en_q);
    end else if (in_win) begin
      for (int w = 0; w < NWIN; w++) begin
        if (int'(w_sel) == w) begin
          case (fld)
            2'd0: cfg_rdata = base_a[w];
            2'd1: cfg_rdata = 32'(size_a[w]);
            2'd2: begin
              if (win_kind_of(w, WPB, NWIN) == WK_MEM)     cfg_rdata = {16'h0, remap_a[w][31:16]};
              else if (win_kind_of(w, WPB, NWIN) == WK_IO) cfg_rdata = remap_a[w][47:16];
            end
            default: begin
              if (win_kind_of(w, WPB, NWIN) == WK_MEM) cfg_rdata = remap_a[w][63:32];
            end
          endcase
        end
      end
    end
  end

  // R8
  cfg_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == ADDR_CFG) |=>
      (cfg_q[FORCE_BIT] && ((cfg_q & ~CFG_MASK & ~(32'h1 << FORCE_BIT)) == 32'h0)));

  // R2
  en_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == ADDR_EN) |=> (en_q == $past(cfg_wdata[EN_W-1:0])));

  // R12
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr != ADDR_CFG) |=> $stable(cfg_q));

endmodule

// File: tb/cpuwin_decoder_tb.sv
`timescale 1ns/100ps
module cpuwin_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = 8'h0;
  logic [31:0] cfg_wdata = 32'h0;
  logic [31:0] cfg_rdata;
  logic [31:0] lk_addr = 32'h0;
  logic        lk_hit;
  logic [3:0]  lk_win;
  logic [63:0] lk_bus_addr;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  cpuwin_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lk_addr(lk_addr),
    .lk_hit(lk_hit), .lk_win(lk_win), .lk_bus_addr(lk_bus_addr)
  );

  // {addr, hit, win, bus}
  localparam logic [100:0] VECS [14] = '{
    {32'h0102_3456, 1'b1, 4'd1,  64'h0000_0002_0102_3456},
    {32'h0109_0000, 1'b1, 4'd1,  64'h0000_0002_0109_0000},
    {32'h010F_FFFF, 1'b1, 4'd1,  64'h0000_0002_010F_FFFF},
    {32'h0110_0000, 1'b1, 4'd2,  64'h0000_0000_ABD5_0000},
    {32'h0117_FFFF, 1'b1, 4'd2,  64'h0000_0000_ABDC_FFFF},
    {32'h0118_0000, 1'b0, 4'd0,  64'h0},
    {32'h0200_FFFF, 1'b1, 4'd0,  64'h0000_0000_0010_FFFF},
    {32'h0201_0000, 1'b0, 4'd0,  64'h0},
    {32'h0000_1234, 1'b1, 4'd5,  64'h0000_0000_0000_1234},
    {32'hF100_0040, 1'b1, 4'd10, 64'h0000_0000_0000_0040},
    {32'hFFFF_FFFF, 1'b1, 4'd9,  64'hFFFF_FFFF_FFFF_FFFF},
    {32'h0300_0000, 1'b0, 4'd0,  64'h0},
    {32'h0400_0000, 1'b0, 4'd0,  64'h0},
    {32'h00FF_FFFF, 1'b0, 4'd0,  64'h0}
  };

  function automatic logic [7:0] wa(input int w, input int f);
    return 8'(16 + 4 * w + f);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    cfg_addr = a;
    #1;
    check(req, 64'(cfg_rdata), 64'(exp));
  endtask

  task automatic look_chk(input string req, input logic [31:0] a, input logic h,
                          input logic [3:0] w, input logic [63:0] b);
    lk_addr = a;
    #1;
    check({req, " hit"}, 64'(lk_hit), 64'(h));
    check({req, " win"}, 64'(lk_win), 64'(w));
    check({req, " bus"}, lk_bus_addr, b);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_chk("R1 cfg", 8'h00, 32'h0080_0000);
    rd_chk("R1 en", 8'h01, 32'h000f_bfff);
    rd_chk("R1 regs base", wa(10, 0), 32'h0100_f100);
    rd_chk("R1 base", wa(1, 0), 32'h0);
    rd_chk("R1 remap hi", wa(1, 3), 32'h0);
    look_chk("R1 io1", 32'h0000_1234, 1'b1, 4'd5, 64'h1234);
    look_chk("R1 regs", 32'hF100_0040, 1'b1, 4'd10, 64'h40);

    // R8 config mask and forced bit
    wr(8'h00, 32'hFFFF_FFFF);
    rd_chk("R8 mask", 8'h00, 32'h0ece_3bff);
    // R7 copy suppressed while bit 27 set
    wr(wa(4, 0), 32'h0000_0400);
    rd_chk("R7 nocopy", wa(4, 2), 32'h0);
    wr(8'h00, 32'h0);
    rd_chk("R8 forced", 8'h00, 32'h0080_0000);

    // R4 base/size masks, R7 copy
    wr(wa(1, 0), 32'hFFFF_FFFF);
    rd_chk("R4 mem base", wa(1, 0), 32'h070f_ffff);
    rd_chk("R7 copy", wa(1, 2), 32'h0000_ffff);
    wr(wa(0, 0), 32'hFFFF_FFFF);
    rd_chk("R4 io base", wa(0, 0), 32'h030f_ffff);
    wr(wa(10, 0), 32'hFFFF_FFFF);
    rd_chk("R4 regs base", wa(10, 0), 32'h000f_ffff);
    wr(wa(1, 1), 32'hFFFF_1234);
    rd_chk("R4 size", wa(1, 1), 32'h0000_1234);

    // window setup
    wr(wa(1, 0), 32'h0100); wr(wa(1, 1), 32'h000F); wr(wa(1, 3), 32'h2);
    wr(wa(2, 0), 32'h0108); wr(wa(2, 1), 32'h000F); wr(wa(2, 2), 32'hABCD);
    wr(wa(0, 0), 32'h0200); wr(wa(0, 1), 32'h0);    wr(wa(0, 2), 32'h0010);
    wr(wa(9, 0), 32'hFFFF); wr(wa(9, 1), 32'h0);    wr(wa(9, 2), 32'hFFFF);
    wr(wa(9, 3), 32'hFFFF_FFFF);
    wr(wa(3, 0), 32'h0001_0300); wr(wa(3, 1), 32'h0);
    wr(wa(10, 0), 32'h0000_F100);
    wr(8'h01, 32'hFFEB_A1FF);
    rd_chk("R2 en mask", 8'h01, 32'h000B_A1FF);

    // R6 read formats
    rd_chk("R6 mem lo", wa(1, 2), 32'h0100);
    rd_chk("R6 mem hi", wa(1, 3), 32'h2);
    rd_chk("R6 io lo", wa(0, 2), 32'h0010);
    rd_chk("R6 mem1 lo", wa(2, 2), 32'hABCD);
    rd_chk("R6 mem hi ones", wa(9, 3), 32'hFFFF_FFFF);

    // R5 halves independent
    wr(wa(1, 2), 32'h7777_0200);
    rd_chk("R5 lo keeps hi", wa(1, 3), 32'h2);
    rd_chk("R5 lo", wa(1, 2), 32'h0200);
    look_chk("R5 R9 xlate", 32'h0102_3456, 1'b1, 4'd1, 64'h0000_0002_0202_3456);
    wr(wa(1, 2), 32'h0100);
    wr(wa(2, 3), 32'h1);
    rd_chk("R5 hi keeps lo", wa(2, 2), 32'hABCD);
    look_chk("R5 R9 hi", 32'h0110_0000, 1'b1, 4'd2, 64'h0000_0001_ABD5_0000);
    wr(wa(2, 3), 32'h0);

    // R3 R9 R10 R11 vector table
    for (int i = 0; i < 14; i++) begin
      look_chk("R3 R9 R10 R11 vec", VECS[i][100:69], VECS[i][68], VECS[i][67:64], VECS[i][63:0]);
    end

    // R12 ignored fields and unmapped addresses
    wr(wa(10, 1), 32'h00FF);
    rd_chk("R12 regs size", wa(10, 1), 32'h0);
    look_chk("R12 regs span", 32'hF101_0000, 1'b0, 4'd0, 64'h0);
    wr(wa(0, 3), 32'h5);
    rd_chk("R12 io hi", wa(0, 3), 32'h0);
    look_chk("R12 io xlate", 32'h0200_0000, 1'b1, 4'd0, 64'h0010_0000);
    rd_chk("R12 unmapped", 8'h3C, 32'h0);
    wr(8'h3C, 32'hFFFF_FFFF);
    rd_chk("R12 cfg kept", 8'h00, 32'h0080_0000);
    rd_chk("R12 en kept", 8'h01, 32'h000B_A1FF);

    // R2 enable window 4 (remap stayed 0 per R7)
    wr(8'h01, 32'h000B_81FF);
    look_chk("R2 R7 win4", 32'h0400_0010, 1'b1, 4'd4, 64'h10);
    // R2 R10 disable window 1, window 2 now wins
    wr(8'h01, 32'h000B_85FF);
    look_chk("R2 R10 win2", 32'h0109_0000, 1'b1, 4'd2, 64'hABCE_0000);

    finish_run();
  end
endmodule